// File: doc/BRIEF.md
# Divided One-Shot / Periodic Countdown Timer

This block is a local countdown timer with a programmable prescaler. Software loads a starting count, picks a clock divider and sets up a control entry that holds an interrupt vector, a mask bit and a mode bit. The counter then steps down once per prescaled tick. In one-shot mode it stops at zero and raises a single interrupt strobe. In periodic mode it reloads the starting value every period and raises a strobe on each reload.

Registers are reached through a plain register port: a write enable, a two-bit address, a 32-bit write word and a combinational read word. The interrupt leaves the block as a one-cycle strobe with the vector beside it. Routing that strobe into an interrupt controller is handled elsewhere.

The divider code is formed from bits 3, 1 and 0 of the divide register, so the encoding is not linear. A periodic period is one tick longer than the loaded value. A loaded value of zero keeps the timer silent in both modes.

Top module: `cntdn_timer`

## Requirements
- R1: After reset the entry register reads 0x0001_0000 (vector 0, mask bit 16 set, periodic bit 17 clear), and the initial count, the current count and the divide register all read 0. The strobe is low.
- R2: The register map is address 0 = entry, 1 = initial count, 2 = current count, 3 = divide. The entry keeps the vector in bits VEC_W-1:0, the mask in bit 16 and the periodic flag in bit 17; all other entry bits read 0. The initial count holds CNT_W bits and reads back zero-extended. The current count is read-only, and writes to address 2 change nothing.
- R3: A divide-register write keeps only bits 0, 1 and 3. Writing 0xFFFF_FFFF reads back 0xB.
- R4: The divider code is {bit3, bit1, bit0} of the divide register. A tick comes every D = 2^((code+1) mod 8) clocks, so code 7 divides by 1, code 0 by 2 and code 6 by 128.
- R5: A write to the initial count loads the count on that clock edge and restarts the prescaler phase. Any count in progress is abandoned and cannot fire. Writes to other addresses leave the stored initial count unchanged.
- R6: One-shot mode (bit 17 = 0) uses t = 1 for the first cycle after the initial-count write edge. The current count in cycle t is max(N - floor((t-1)/D), 0). Exactly one strobe appears, in cycle t = (N+1)*D + 1. The count then stays at 0 and no further strobe follows.
- R7: Periodic mode (bit 17 = 1) shows the count N - (floor((t-1)/D) mod (N+1)) in cycle t. A strobe appears in every cycle t > 1 with (t-1) mod ((N+1)*D) = 0.
- R8: An initial count of 0 produces no strobe in either mode, and the count stays 0.
- R9: While the mask bit is set, expiries raise no strobe, but counting and reloading go on. An entry write takes effect from the next cycle, so clearing the mask lets the next expiry through.
- R10: The strobe is one cycle wide. In that cycle the vector output equals the entry vector that was in force at the expiry.
- R11: A change of the divide register takes effect at the next prescaler boundary of the divider already running. The boundary already under way is not cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register select |
| regWdata | input | 32 | Register write word |
| regRdata | output | 32 | Register read word (combinational on regAddr) |
| irqStrobe | output | 1 | One-cycle interrupt strobe |
| irqVector | output | VEC_W | Vector that goes with the strobe |

## Verification
The bench builds the timer with CNT_W = 8 and VEC_W = 8. With an 8-bit count, the largest starting value of 255 can be run to expiry in a few hundred cycles. All eight divider codes, up to divide-by-128, fit in a short run. Expected counts and strobe cycles come from the closed-form formulas in R6 and R7, checked cycle by cycle over one-shot and periodic runs. Separate runs cover a mid-run divider change, a restart, and masking followed by unmasking.

// File: rtl/cntdn_pkg.sv
package cntdn_pkg;

  localparam int DIVCODE_W = 3;
  localparam int MASK_BIT  = 16;
  localparam int PER_BIT   = 17;

  localparam logic [1:0] ADDR_ENTRY = 2'd0;
  localparam logic [1:0] ADDR_INIT  = 2'd1;
  localparam logic [1:0] ADDR_CUR   = 2'd2;
  localparam logic [1:0] ADDR_DIV   = 2'd3;

  localparam logic [3:0] DIV_KEEP = 4'hB;

  typedef logic [DIVCODE_W-1:0] shift_t;

  // strobes and levels passed from control to datapath
  typedef struct packed {
    logic   restart;
    logic   periodic;
    logic   masked;
    shift_t shift;
  } tmrCtl_t;

  // prescale shift = (code + 1) mod 8
  function automatic shift_t divShift(input shift_t code);
    return code + shift_t'(1);
  endfunction

endpackage

// File: rtl/cntdn_ctrl.sv
module cntdn_ctrl
  import cntdn_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [CNT_W-1:0] curCnt,
  output tmrCtl_t          ctl,
  output logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] initVal,
  output logic [VEC_W-1:0] vector
);

  logic [VEC_W-1:0] vecReg;
  logic             maskReg;
  logic             perReg;
  logic [CNT_W-1:0] initReg;
  logic [3:0]       divReg;
  logic             wrEntry;
  logic             wrInit;
  logic             wrDiv;
  logic             unusedWdata;

  always_comb begin
    wrEntry = regWe && (regAddr == ADDR_ENTRY);
    wrInit  = regWe && (regAddr == ADDR_INIT);
    wrDiv   = regWe && (regAddr == ADDR_DIV);
  end

  assign unusedWdata = ^regWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg  <= '0;
      maskReg <= 1'b1;
      perReg  <= 1'b0;
      initReg <= '0;
      divReg  <= '0;
    end else begin
      if (wrEntry) begin
        vecReg  <= regWdata[VEC_W-1:0];
        maskReg <= regWdata[MASK_BIT];
        perReg  <= regWdata[PER_BIT];
      end
      if (wrInit) initReg <= regWdata[CNT_W-1:0];
      if (wrDiv)  divReg  <= regWdata[3:0] & DIV_KEEP;
    end
  end

  always_comb begin
    ctl.restart  = wrInit;
    ctl.periodic = perReg;
    ctl.masked   = maskReg;
    ctl.shift    = divShift({divReg[3], divReg[1:0]});
    loadVal      = regWdata[CNT_W-1:0];
    initVal      = initReg;
    vector       = vecReg;
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_ENTRY: begin
        regRdata[VEC_W-1:0] = vecReg;
        regRdata[MASK_BIT]  = maskReg;
        regRdata[PER_BIT]   = perReg;
      end
      ADDR_INIT: regRdata = 32'(initReg);
      ADDR_CUR:  regRdata = 32'(curCnt);
      ADDR_DIV:  regRdata = 32'(divReg);
      default:   regRdata = '0;
    endcase
  end

  AST_INIT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!(regWe && regAddr == ADDR_INIT)) |=> $stable(initVal)); // R5

endmodule

// File: rtl/cntdn_dp.sv
module cntdn_dp
  import cntdn_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCtl_t          ctl,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] initVal,
  input  logic [VEC_W-1:0] vecIn,
  output logic [CNT_W-1:0] curCnt,
  output logic             irqStrobe,
  output logic [VEC_W-1:0] irqVector
);

  localparam int PRE_W = (1 << DIVCODE_W) - 1;
  localparam logic [PRE_W:0] PW_ONE = 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic [PRE_W:0]   prePow;
  shift_t           curShift;
  logic             armed;
  logic             tick;
  logic             fireQ;
  logic [VEC_W-1:0] vecQ;

  always_comb begin
    prePow   = PW_ONE << curShift;
    preLimit = PRE_W'(prePow - PW_ONE);
    tick     = (preCnt == preLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      curShift <= divShift('0);
      curCnt   <= '0;
      armed    <= 1'b0;
      fireQ    <= 1'b0;
      vecQ     <= '0;
    end else if (ctl.restart) begin
      preCnt   <= '0;
      curShift <= ctl.shift;
      curCnt   <= loadVal;
      armed    <= |loadVal;
      fireQ    <= 1'b0;
    end else begin
      fireQ <= 1'b0;
      if (tick) begin
        preCnt   <= '0;
        curShift <= ctl.shift;
        if (curCnt != '0) begin
          curCnt <= curCnt - CNT_W'(1);
        end else if (armed) begin
          fireQ <= !ctl.masked;
          vecQ  <= vecIn;
          if (ctl.periodic) curCnt <= initVal;
          else              armed  <= 1'b0;
        end
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  assign irqStrobe = fireQ;
  assign irqVector = vecQ;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqStrobe |=> !irqStrobe); // R10

  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    irqStrobe |-> !$past(ctl.masked)); // R9

  AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restart |=> (curCnt == $past(loadVal))); // R5

  AST_ONESHOT_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.restart && !ctl.periodic && curCnt == '0) |=> (curCnt == '0)); // R6

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.restart && curCnt != '0) |=>
      (curCnt == $past(curCnt) || curCnt == $past(curCnt) - CNT_W'(1))); // R6

endmodule

// File: rtl/cntdn_timer.sv
module cntdn_timer
  import cntdn_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  output logic             irqStrobe,
  output logic [VEC_W-1:0] irqVector
);

  tmrCtl_t          ctl;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] initVal;
  logic [CNT_W-1:0] curCnt;
  logic [VEC_W-1:0] vector;

  cntdn_ctrl #(.CNT_W(CNT_W), .VEC_W(VEC_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .curCnt   (curCnt),
    .ctl      (ctl),
    .loadVal  (loadVal),
    .initVal  (initVal),
    .vector   (vector)
  );

  cntdn_dp #(.CNT_W(CNT_W), .VEC_W(VEC_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .loadVal   (loadVal),
    .initVal   (initVal),
    .vecIn     (vector),
    .curCnt    (curCnt),
    .irqStrobe (irqStrobe),
    .irqVector (irqVector)
  );

endmodule

// File: tb/test_cntdn_timer.sv
`timescale 1ns/1ps
module test_cntdn_timer;

  localparam int CNT_W = 8;
  localparam int VEC_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWe = 1'b0;
  logic [1:0]       regAddr = 2'd2;
  logic [31:0]      regWdata = '0;
  logic [31:0]      regRdata;
  logic             irqStrobe;
  logic [VEC_W-1:0] irqVector;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cntdn_timer #(.CNT_W(CNT_W), .VEC_W(VEC_W)) i_cntdn_timer (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .irqStrobe(irqStrobe), .irqVector(irqVector)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // write lands on the posedge after the call; returns mid-cycle t=1
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regAddr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  function automatic logic [31:0] divBits(input int code);
    return {28'd0, code[2], 1'b0, code[1:0]};
  endfunction

  function automatic int divOf(input int code);
    return 1 << ((code + 1) % 8);
  endfunction

  // R4 R6 R7 R8 R10: run from an initial-count write and compare each cycle
  task automatic runCase(input int code, input bit per, input int n, input int vec);
    int d, tEnd;
    d = divOf(code);
    tEnd = per ? 3 * (n + 1) * d + 2 : (n + 1) * d + 2 * d + 3;
    if (n == 0) tEnd = 40;
    wr(2'd0, (32'(per) << 17) | 32'(vec));
    wr(2'd3, divBits(code));
    wr(2'd1, 32'(n));
    for (int t = 1; t <= tEnd; t++) begin
      int j, expCnt;
      bit expS;
      if (t > 1) @(negedge clk);
      #1;
      j = (t - 1) / d;
      if (per) begin
        expCnt = (n == 0) ? 0 : n - (j % (n + 1));
        expS = (n != 0) && (t > 1) && (((t - 1) % ((n + 1) * d)) == 0);
      end else begin
        expCnt = (n > j) ? n - j : 0;
        expS = (n != 0) && (t == (n + 1) * d + 1);
      end
      if (n == 0) begin
        check("R8 zero count", longint'(regRdata), 0);
        check("R8 zero strobe", longint'(irqStrobe), 0);
      end else if (per) begin
        check("R4/R7 periodic count", longint'(regRdata), expCnt);
        check("R4/R7 periodic strobe", longint'(irqStrobe), longint'(expS));
      end else begin
        check("R4/R6 oneshot count", longint'(regRdata), expCnt);
        check("R4/R6 oneshot strobe", longint'(irqStrobe), longint'(expS));
      end
      if (irqStrobe) check("R10 vector", longint'(irqVector), vec);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all requirements act=hung exp=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1 check("R1 strobe low", longint'(irqStrobe), 0);
    rd(2'd0, v); check("R1 entry reset", longint'(v), 32'h0001_0000);
    rd(2'd1, v); check("R1 init reset", longint'(v), 0);
    rd(2'd2, v); check("R1 cur reset", longint'(v), 0);
    rd(2'd3, v); check("R1 div reset", longint'(v), 0);

    // R2 / R3 register map
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R3 div keeps bits 0,1,3", longint'(v), 32'hB);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R2 entry fields", longint'(v), 32'h0003_00FF);
    wr(2'd2, 32'h55);
    rd(2'd2, v); check("R2 cur read-only", longint'(v), 0);
    wr(2'd1, 32'h1A5);
    rd(2'd1, v); check("R2 init readback", longint'(v), 32'hA5);
    wr(2'd0, 32'h0001_0000);
    wr(2'd1, 32'h0);

    // R4/R6 one-shot sweep over every divider code
    for (int c = 0; c < 8; c++) begin
      runCase(c, 1'b0, 1, 8'h20 + c);
      runCase(c, 1'b0, 3, 8'h40 + c);
    end
    runCase(7, 1'b0, 255, 8'hFE);  // R6 largest count

    // R7 periodic
    for (int c = 0; c < 3; c++) begin
      runCase(c, 1'b1, 1, 8'h60 + c);
      runCase(c, 1'b1, 4, 8'h70 + c);
    end
    runCase(7, 1'b1, 2, 8'h81);
    runCase(7, 1'b1, 255, 8'h82);

    // R8 zero initial count
    runCase(7, 1'b0, 0, 8'h90);
    runCase(7, 1'b1, 0, 8'h91);

    // R9 mask then unmask (periodic, N=2, D=1)
    wr(2'd0, 32'h0003_00A5);
    wr(2'd3, divBits(7));
    wr(2'd1, 32'd2);
    for (int t = 1; t <= 20; t++) begin
      bit expS;
      if (t > 1) @(negedge clk);
      if (t == 9) begin regWe = 1'b0; regAddr = 2'd2; end
      #1;
      expS = (((t - 1) % 3) == 0) && (t >= 10);
      check("R9 masked/unmasked strobe", longint'(irqStrobe), longint'(expS));
      check("R9 count runs while masked", longint'(regRdata), 2 - ((t - 1) % 3));
      if (t == 8) begin regWe = 1'b1; regAddr = 2'd0; regWdata = 32'h0002_00A5; end
    end

    // R11 divider change mid-run (one-shot, N=2, D=4 then D=1)
    wr(2'd0, 32'h0000_0033);
    wr(2'd3, divBits(1));
    wr(2'd1, 32'd2);
    for (int t = 1; t <= 16; t++) begin
      int expCnt;
      if (t > 1) @(negedge clk);
      if (t == 6) begin regWe = 1'b0; regAddr = 2'd2; end
      #1;
      expCnt = (t < 5) ? 2 : (t < 9) ? 1 : 0;
      check("R11 strobe at old boundary", longint'(irqStrobe), longint'(t == 10));
      if (t != 6) check("R11 count", longint'(regRdata), expCnt);
      if (t == 5) begin regWe = 1'b1; regAddr = 2'd3; regWdata = divBits(7); end
    end

    // R5 restart mid-count (one-shot D=1, N=5 then N=6 written in cycle 3)
    wr(2'd3, divBits(7));
    wr(2'd1, 32'd5);
    for (int t = 1; t <= 16; t++) begin
      int expCnt;
      if (t > 1) @(negedge clk);
      if (t == 4) begin regWe = 1'b0; regAddr = 2'd2; end
      #1;
      if (t <= 3) expCnt = 5 - (t - 1);
      else expCnt = (6 - (t - 4) > 0) ? 6 - (t - 4) : 0;
      check("R5 restart strobe", longint'(irqStrobe), longint'(t == 11));
      check("R5 restart count", longint'(regRdata), expCnt);
      if (t == 3) begin regWe = 1'b1; regAddr = 2'd1; regWdata = 32'd6; end
    end
    rd(2'd1, v); check("R5 init kept", longint'(v), 6);

    summary();
  end

endmodule